// File: doc/BRIEF.md
# QDR Read Data Capture

This block takes the 18-bit read data that a quad-data-rate SRAM returns at double data rate, latches it with the echo clock that the memory sends back, and delivers 36-bit words to the controller's 1x clock domain. The memory launches one beat after each rising edge of the echo clock and one after each falling edge. Each beat is latched on the echo clock edge opposite to the one that launched it. The beat latched on a falling edge becomes the low half of a word. The beat latched on the following rising edge becomes the high half.

The command path pulses `rd_issue` once for each read it sends to the memory. A delay line in the 1x domain turns that pulse into a capture window. The echo-clock side uses the window to decide which joined words to keep. Only the words it keeps enter a two-entry buffer. The buffer's pointers are Gray coded and pass through two-stage synchronisers in each direction. On the 1x side, every word leaving the buffer is presented with a single-cycle `rd_valid` pulse. `rd_word` holds the last word it delivered until the next one arrives.

Top module: `qdr_rd_capture`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read completes, `rd_valid` is 0 and `rd_word` is 0.
- R2: `rd_word[17:0]` holds the beat latched on the falling edge of `cq_clk` that precedes the word's high beat.
- R3: `rd_word[35:18]` holds the beat latched on the first rising edge of `cq_clk` after 1x edge n+RD_LAT-1, where n is the 1x edge that sampled `rd_issue` high.
- R4: Beats on `rd_dq` outside a capture window are ignored. They raise no `rd_valid`, and `rd_word` keeps its last value.
- R5: For a read sampled at 1x edge n, `rd_valid` is high for exactly the cycle that follows 1x edge n+RD_LAT+2. This holds when `cq_clk` lags `clk_sys` by less than half a period. The default RD_LAT is 2.
- R6: With the default depth, reads spaced at least three 1x cycles apart each produce exactly one `rd_valid` pulse. The words come out in issue order, and none is lost.
- R7: Asserting `rst_n` drops every read still in flight. No `rd_valid` appears for it after reset is released, and `rd_word` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Controller 1x clock; also the phase reference for the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| cq_clk | input | 1 | Echo clock returned from the memory; latches all read beats |
| rd_dq | input | 18 | Double-data-rate read beats from the memory |
| rd_issue | input | 1 | One-cycle pulse from the command path for each read sent (1x domain) |
| rd_word | output | 36 | Joined read word; low beat in bits 17:0 |
| rd_valid | output | 1 | One-cycle pulse marking a new `rd_word` |

## Verification
The main function is exercised with several kinds of word. Distinct low and high halves detect swapped or mis-edged halves. All-ones against all-zeros and alternating bits expose bit crossings between the halves. Walking single bits in both halves catch shifted or dropped lanes. The memory model drives a changing pseudo-random beat whenever no read is due. This separates window-gated capture from free-running capture, and it shows that a stale echo edge cannot be mistaken for the right one. Read spacings of three and four cycles check ordering and delivery at the closest supported rate. A read cut off by reset checks that nothing leaks out afterwards.

// File: rtl/qcap_pkg.sv
package qcap_pkg;

    localparam int PTR_MAX_W = 8;

    typedef logic [PTR_MAX_W-1:0] ptr_t;

    function automatic ptr_t bin_to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray_to_bin(ptr_t g);
        ptr_t b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/qcap_sync.sv
module qcap_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/qcap_rd_track.sv
module qcap_rd_track #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    output logic window
);

    localparam int CNT_W = $clog2(LAT + 1) + 1;

    typedef struct packed {
        logic [LAT-1:0] pipe;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.pipe = {trk_q.pipe[LAT-2:0], rd_issue};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign window = trk_q.pipe[LAT-1];

    // Checker: reads accepted but not yet turned into a window
    logic [CNT_W-1:0] inflight_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + CNT_W'(rd_issue) - CNT_W'(window);
    end

    AST_WINDOW_HAS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        window |-> (inflight_q != '0)); // R5
    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CNT_W'(LAT)); // R5

endmodule

// File: rtl/qcap_ddr_in.sv
module qcap_ddr_in #(
    parameter int BW = 18
) (
    input  logic            cq_clk,
    input  logic            rst_n,
    input  logic [BW-1:0]   dq,
    output logic [2*BW-1:0] word
);

    typedef struct packed {
        logic [BW-1:0] lo;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.lo = dq;
    end

    // Beat launched after the rising edge is latched on the falling edge
    always_ff @(negedge cq_clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // The high beat is latched by the buffer on the next rising edge
    assign word = {dq, cap_q.lo};

endmodule

// File: rtl/qcap_cdc_buf.sv
module qcap_cdc_buf
    import qcap_pkg::*;
#(
    parameter int DW          = 36,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] rd_word,
    output logic          rd_valid
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
    } wside_t;

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic [DW-1:0]    word;
        logic             valid;
    } rside_t;

    wside_t ws_d, ws_q;
    rside_t rs_d, rs_q;

    logic [DW-1:0]    mem_q [DEPTH];
    logic [PTR_W-1:0] rgray_w, wgray_r;
    logic [PTR_W-1:0] rbin_w,  wbin_r;
    logic             full, empty, wr_go;

    qcap_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rs_q.gray),
        .q     (rgray_w)
    );

    qcap_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (ws_q.gray),
        .q     (wgray_r)
    );

    // ---------------- write side (echo clock) ----------------
    assign rbin_w = PTR_W'(gray_to_bin(ptr_t'(rgray_w)));
    assign full   = (ws_q.bin[PTR_W-1] != rbin_w[PTR_W-1]) &&
                    (ws_q.bin[IDX_W-1:0] == rbin_w[IDX_W-1:0]);
    assign wr_go  = wr_en && !full;

    always_comb begin
        ws_d = ws_q;
        if (wr_go) begin
            ws_d.bin  = ws_q.bin + 1'b1;
            ws_d.gray = PTR_W'(bin_to_gray(ptr_t'(ws_d.bin)));
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) ws_q <= '0;
        else        ws_q <= ws_d;
    end

    always_ff @(posedge wclk) begin
        if (wr_go) mem_q[ws_q.bin[IDX_W-1:0]] <= wr_word;
    end

    // ---------------- read side (1x clock) ----------------
    assign wbin_r = PTR_W'(gray_to_bin(ptr_t'(wgray_r)));
    assign empty  = (wbin_r == rs_q.bin);

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = 1'b0;
        if (!empty) begin
            rs_d.word  = mem_q[rs_q.bin[IDX_W-1:0]];
            rs_d.valid = 1'b1;
            rs_d.bin   = rs_q.bin + 1'b1;
            rs_d.gray  = PTR_W'(bin_to_gray(ptr_t'(rs_d.bin)));
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_word  = rs_q.word;
    assign rd_valid = rs_q.valid;

    AST_NO_OVERWRITE: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_en |-> !full); // R6
    AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(ws_q.gray ^ $past(ws_q.gray)) <= 1); // R6
    AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rs_q.gray ^ $past(rs_q.gray)) <= 1); // R6
    AST_WORD_HOLDS: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_word != $past(rd_word)) |-> rd_valid); // R4

endmodule

// File: rtl/qdr_rd_capture.sv
module qdr_rd_capture #(
    parameter int BEAT_W      = 18,
    parameter int RD_LAT      = 2,
    parameter int BUF_DEPTH   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_sys,
    input  logic                rst_n,
    input  logic                cq_clk,
    input  logic [BEAT_W-1:0]   rd_dq,
    input  logic                rd_issue,
    output logic [2*BEAT_W-1:0] rd_word,
    output logic                rd_valid
);

    localparam int WORD_W = 2 * BEAT_W;
    localparam int PEND_W = $clog2(RD_LAT + BUF_DEPTH + 4) + 2;

    logic              window;
    logic [WORD_W-1:0] cap_word;

    qcap_rd_track #(.LAT(RD_LAT)) u_track (
        .clk      (clk_sys),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .window   (window)
    );

    qcap_ddr_in #(.BW(BEAT_W)) u_ddr (
        .cq_clk (cq_clk),
        .rst_n  (rst_n),
        .dq     (rd_dq),
        .word   (cap_word)
    );

    qcap_cdc_buf #(.DW(WORD_W), .DEPTH(BUF_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_buf (
        .wclk     (cq_clk),
        .rclk     (clk_sys),
        .rst_n    (rst_n),
        .wr_en    (window),
        .wr_word  (cap_word),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    // Checker: reads issued and not yet delivered
    logic [PEND_W-1:0] pend_q;
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_q + PEND_W'(rd_issue) - PEND_W'(rd_valid);
    end

    AST_VALID_HAS_READ: assert property (@(posedge clk_sys) disable iff (!rst_n)
        rd_valid |-> (pend_q != '0)); // R6
    AST_VALID_SINGLE: assert property (@(posedge clk_sys) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6

endmodule

// File: tb/qdr_rd_capture_bench.sv
module qdr_rd_capture_bench;

    localparam int BW  = 18;
    localparam int WW  = 36;
    localparam int LAT = 2;

    logic          clk_sys  = 1'b0;
    logic          cq_clk   = 1'b0;
    logic          rst_n    = 1'b0;
    logic          rd_issue = 1'b0;
    logic [BW-1:0] rd_dq    = '0;
    logic [BW-1:0] junk     = 18'h15A5A;
    logic [WW-1:0] rd_word;
    logic          rd_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nvalid = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [WW-1:0] w;
        int            due;
    } exp_t;

    typedef struct {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
        longint        t;
    } beat_t;

    exp_t  sbq[$];
    beat_t memq[$];

    qdr_rd_capture #(.BEAT_W(BW), .RD_LAT(LAT)) u_qdr_rd_capture (
        .clk_sys  (clk_sys),
        .rst_n    (rst_n),
        .cq_clk   (cq_clk),
        .rd_dq    (rd_dq),
        .rd_issue (rd_issue),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    always #5 clk_sys = ~clk_sys;

    initial begin
        #3;
        forever #5 cq_clk = ~cq_clk;
    end

    always @(posedge clk_sys) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_sys);
    endtask

    // Driver: one read, with its expected word and its beats for the memory
    task automatic do_read(input logic [BW-1:0] lo, input logic [BW-1:0] hi);
        exp_t  e;
        beat_t b;
        @(negedge clk_sys);
        rd_issue = 1'b1;
        e.w   = {hi, lo};
        e.due = cyc + LAT + 3;
        sbq.push_back(e);
        b.lo = lo;
        b.hi = hi;
        b.t  = longint'($time) + 10 * (LAT - 1);
        memq.push_back(b);
        @(negedge clk_sys);
        rd_issue = 1'b0;
    endtask

    // Memory model: low beat after the echo rising edge, high beat after the falling edge
    initial begin
        beat_t cur;
        forever begin
            @(posedge clk_sys);
            #5;
            if (memq.size() > 0 && memq[0].t == longint'($time)) begin
                cur = memq.pop_front();
                rd_dq = cur.lo;
                #4;
                rd_dq = cur.hi;
            end else begin
                junk  = {junk[BW-2:0], junk[BW-1] ^ junk[BW-8]};
                rd_dq = junk;
                #4;
                rd_dq = ~junk;
            end
        end
    end

    // Monitor / scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk_sys);
            if (rst_n && rd_valid) begin
                nvalid++;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R4", "valid with no read pending", 64'(rd_word), 64'(0));
                end else begin
                    e = sbq.pop_front();
                    chk(rd_word[BW-1:0] == e.w[BW-1:0], "R2", "low half",
                        64'(rd_word[BW-1:0]), 64'(e.w[BW-1:0]));
                    chk(rd_word[WW-1:BW] == e.w[WW-1:BW], "R3", "high half",
                        64'(rd_word[WW-1:BW]), 64'(e.w[WW-1:BW]));
                    chk(cyc == e.due, "R5", "valid cycle", 64'(cyc), 64'(e.due));
                end
            end
        end
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [WW-1:0] held;
        int            nv;

        // R1: reset state
        idle(3);
        chk(rd_valid == 1'b0, "R1", "valid in reset", 64'(rd_valid), 64'(0));
        chk(rd_word == '0, "R1", "word in reset", 64'(rd_word), 64'(0));
        rst_n = 1'b1;
        idle(4);
        chk(rd_valid == 1'b0, "R1", "valid after reset", 64'(rd_valid), 64'(0));
        chk(rd_word == '0, "R1", "word after reset", 64'(rd_word), 64'(0));

        // R2 R3 R5: single read with distinct halves
        do_read(18'h12345, 18'h2ABCD);
        idle(8);

        // R6: back-to-back at spacing 3 with contrasting patterns
        do_read(18'h00001, 18'h20000); idle(1);
        do_read(18'h3FFFF, 18'h00000); idle(1);
        do_read(18'h15555, 18'h2AAAA); idle(1);
        do_read(18'h0F0F0, 18'h30F0F); idle(1);
        do_read(18'h00000, 18'h3FFFF); idle(1);

        // walking bits, spacing 4
        for (int i = 0; i < 4; i++) begin
            do_read(18'(1 << (i * 4)), 18'(1 << (17 - i * 4)));
            idle(2);
        end
        idle(10);
        chk(sbq.size() == 0, "R6", "reads delivered", 64'(sbq.size()), 64'(0));

        // R4: long stretch of changing beats with no read
        held = rd_word;
        nv   = nvalid;
        idle(25);
        chk(rd_word == held, "R4", "word held while idle", 64'(rd_word), 64'(held));
        chk(nvalid == nv, "R4", "no valid while idle", 64'(nvalid), 64'(nv));

        // R7: reset with a read in flight
        nv = nvalid;
        do_read(18'h0AAAA, 18'h15555);
        rst_n = 1'b0;
        sbq.delete();
        memq.delete();
        idle(3);
        chk(rd_word == '0, "R7", "word cleared by reset", 64'(rd_word), 64'(0));
        chk(rd_valid == 1'b0, "R1", "valid low in reset", 64'(rd_valid), 64'(0));
        rst_n = 1'b1;
        idle(12);
        chk(nvalid == nv, "R7", "dropped read stays silent", 64'(nvalid), 64'(nv));
        chk(rd_word == '0, "R7", "word stays zero", 64'(rd_word), 64'(0));

        // recovery after reset
        do_read(18'h01234, 18'h3CDEF);
        idle(10);
        chk(sbq.size() == 0, "R6", "read after reset delivered", 64'(sbq.size()), 64'(0));
        chk(nvalid == nv + 1, "R6", "one pulse per read", 64'(nvalid), 64'(nv + 1));

        finish_up();
    end

endmodule